// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches a receive FIFO and raises a one-cycle interrupt when characters have been sitting unread for a programmed number of serial bit periods. No serial line drives it. The bit period is produced locally from a 16-bit baud increment, so software that programs a timeout in bit times sees the same delay it would get from a conventional serial receiver at that baud rate.

A 16-bit phase accumulator adds the increment on every clock. Each carry out of the accumulator is one oversample tick, and every sixteenth oversample tick is one bit time. A 24-bit counter counts bit times from the most recent FIFO activity and fires once when it reaches the programmed limit.

Any push or pop restarts both the counter and the phase of the tick generator. An empty FIFO or a cleared enable also holds the timer in restart. The FIFO and the serial receiver lie outside the block. Its host supplies the FIFO's non-empty level and its push and pop strobes.

Top module: `rx_idle_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `timeout_irq_o` is low.
- R2: Every clock edge adds `baud_inc_i` to a 16-bit accumulator, and each carry out is one oversample tick. Sixteen oversample ticks form one bit time. The edge on which the timer restarts is edge 0. For a limit T, `timeout_irq_o` is high during the cycle after edge n, where n = ceil(16·T·65536 / baud_inc_i), and it is low before that.
- R3: A cycle with `rx_push_i` high restarts the timer: the count of R2 begins again from the edge that samples the push, and the interrupt is low in the following cycle.
- R4: A cycle with `rx_pop_i` high restarts the timer in the same way as R3.
- R5: While `rx_fifo_nonempty_i` is low, the timer is held at zero and no interrupt is raised. Counting starts on the first edge that samples the level high.
- R6: The interrupt is high for exactly one cycle. It stays low after that until a restart occurs, however long the FIFO stays unread.
- R7: A limit `timeout_val_i` of zero never raises the interrupt.
- R8: With `timeout_en_i` low, no interrupt is raised and the timer is held in restart. Counting starts on the first edge that samples the enable high.
- R9: An increment of zero produces no ticks, so no interrupt is raised.
- R10: After the timer has fired, a restart arms it again, and it fires again after the full period of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_inc_i | input | 16 | Phase increment added every clock |
| timeout_val_i | input | 24 | Timeout limit in bit times |
| timeout_en_i | input | 1 | Timeout feature enable |
| rx_fifo_nonempty_i | input | 1 | High while the RX FIFO holds at least one character |
| rx_push_i | input | 1 | One-cycle strobe for a character written into the RX FIFO |
| rx_pop_i | input | 1 | One-cycle strobe for a character read from the RX FIFO |
| timeout_irq_o | output | 1 | One-cycle timeout interrupt pulse |

## Verification
The timer is first swept over increments with a power-of-two period, over increments that leave a remainder (such as 0x5555 and 0x7FFF), and over the extreme value 0xFFFF, each with limits of one to three bit times. The firing cycle is compared against the closed-form ceiling expression. A power-of-two increment shows that the oversample and bit-time divisions are correct. A non-dividing increment shows that the accumulator keeps its fractional remainder instead of clearing it on each carry.

Pushes and pops placed in the middle of a count show that a restart moves the firing point back by exactly one full period. Raising the enable or the non-empty level after a hold shows that counting starts on the first edge that samples the level high. Long quiet windows after each firing, and under a zero limit, a zero increment, a cleared enable or an empty FIFO, separate a single-shot interrupt from a re-firing or free-running one.

// File: rtl/rx_idle_timer_pkg.sv
package rx_idle_timer_pkg;
    // Default geometry of the timeout timer
    localparam int unsigned INC_WIDTH     = 16;
    localparam int unsigned OS_PER_BIT    = 16;
    localparam int unsigned LIMIT_WIDTH   = 24;
endpackage

// File: rtl/rxto_bit_tick.sv
// Phase-accumulator bit-time generator: carry = oversample tick,
// every OS_PER_BIT-th oversample tick = one bit time.
module rxto_bit_tick #(
    parameter int unsigned INC_W  = rx_idle_timer_pkg::INC_WIDTH,
    parameter int unsigned OS_NUM = rx_idle_timer_pkg::OS_PER_BIT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic [INC_W-1:0] inc_i,
    output logic             bit_tick_o
);
    localparam int unsigned OS_W = (OS_NUM > 1) ? $clog2(OS_NUM) : 1;
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_NUM - 1);

    typedef struct packed {
        logic [INC_W-1:0] acc;
        logic [OS_W-1:0]  os;
    } tick_st_t;

    tick_st_t       st_d, st_q;
    logic [INC_W:0] sum;
    logic           os_tick;

    always_comb begin
        sum        = {1'b0, st_q.acc} + {1'b0, inc_i};
        os_tick    = sum[INC_W];
        bit_tick_o = os_tick && (st_q.os == OS_LAST);
        st_d       = st_q;
        if (restart_i) begin
            st_d = '0;
        end else begin
            st_d.acc = sum[INC_W-1:0];
            if (os_tick) begin
                st_d.os = (st_q.os == OS_LAST) ? '0 : st_q.os + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/rxto_idle_count.sv
// Bit-time counter with single-shot comparison against the limit.
module rxto_idle_count #(
    parameter int unsigned LIM_W = rx_idle_timer_pkg::LIMIT_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             bit_tick_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             irq_o
);
    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic             fired;
        logic             irq;
    } cnt_st_t;

    cnt_st_t        st_d, st_q;
    logic [LIM_W:0] next_cnt;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        next_cnt = {1'b0, st_q.cnt} + 1'b1;
        if (restart_i) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (bit_tick_i && !st_q.fired) begin
            if (st_q.cnt != '1) begin
                st_d.cnt = next_cnt[LIM_W-1:0];
            end
            if ((limit_i != '0) && (next_cnt >= {1'b0, limit_i})) begin
                st_d.irq   = 1'b1;
                st_d.fired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int unsigned INC_W  = rx_idle_timer_pkg::INC_WIDTH,
    parameter int unsigned OS_NUM = rx_idle_timer_pkg::OS_PER_BIT,
    parameter int unsigned LIM_W  = rx_idle_timer_pkg::LIMIT_WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INC_W-1:0] baud_inc_i,
    input  logic [LIM_W-1:0] timeout_val_i,
    input  logic             timeout_en_i,
    input  logic             rx_fifo_nonempty_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    output logic             timeout_irq_o
);
    logic restart;
    logic bit_tick;

    // Any FIFO activity, an empty FIFO or a disabled feature restarts timing
    assign restart = rx_push_i | rx_pop_i | ~rx_fifo_nonempty_i | ~timeout_en_i;

    rxto_bit_tick #(
        .INC_W  (INC_W),
        .OS_NUM (OS_NUM)
    ) u_tick (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart),
        .inc_i      (baud_inc_i),
        .bit_tick_o (bit_tick)
    );

    rxto_idle_count #(
        .LIM_W (LIM_W)
    ) u_count (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart),
        .bit_tick_i (bit_tick),
        .limit_i    (timeout_val_i),
        .irq_o      (timeout_irq_o)
    );
endmodule

// File: rtl/rx_idle_timer_checker.sv
module rx_idle_timer_checker #(
    parameter int unsigned INC_W = rx_idle_timer_pkg::INC_WIDTH,
    parameter int unsigned LIM_W = rx_idle_timer_pkg::LIMIT_WIDTH
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [INC_W-1:0] baud_inc_i,
    input logic [LIM_W-1:0] timeout_val_i,
    input logic             timeout_en_i,
    input logic             rx_fifo_nonempty_i,
    input logic             rx_push_i,
    input logic             rx_pop_i,
    input logic             timeout_irq_o
);
    a_r3_push_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_push_i |=> !timeout_irq_o);

    a_r4_pop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_pop_i |=> !timeout_irq_o);

    a_r5_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_fifo_nonempty_i |=> !timeout_irq_o);

    a_r6_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_irq_o |=> !timeout_irq_o);

    a_r7_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_val_i == '0) |=> !timeout_irq_o);

    a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !timeout_en_i |=> !timeout_irq_o);

    a_r9_zero_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (baud_inc_i == '0) |=> !timeout_irq_o);
endmodule

bind rx_idle_timer rx_idle_timer_checker #(
    .INC_W (INC_W),
    .LIM_W (LIM_W)
) u_checker (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .baud_inc_i         (baud_inc_i),
    .timeout_val_i      (timeout_val_i),
    .timeout_en_i       (timeout_en_i),
    .rx_fifo_nonempty_i (rx_fifo_nonempty_i),
    .rx_push_i          (rx_push_i),
    .rx_pop_i           (rx_pop_i),
    .timeout_irq_o      (timeout_irq_o)
);

// File: tb/rx_idle_timer_bench.sv
module rx_idle_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] inc = '0;
    logic [23:0] val = '0;
    logic        en = 1'b0;
    logic        ne = 1'b0;
    logic        push = 1'b0;
    logic        pop = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rx_idle_timer u_rx_idle_timer (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .baud_inc_i         (inc),
        .timeout_val_i      (val),
        .timeout_en_i       (en),
        .rx_fifo_nonempty_i (ne),
        .rx_push_i          (push),
        .rx_pop_i           (pop),
        .timeout_irq_o      (irq)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_n(input longint i, input longint t);
        return (16 * t * 65536 + i - 1) / i;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_push();
        push = 1'b1;
        step();
        push = 1'b0;
    endtask

    task automatic strobe_pop();
        pop = 1'b1;
        step();
        pop = 1'b0;
    endtask

    // Count edges until irq is seen; -1 if not within limit
    task automatic measure(input int limit, output int got);
        got = -1;
        for (int k = 1; k <= limit; k++) begin
            step();
            if (irq) begin
                got = k;
                break;
            end
        end
    endtask

    task automatic quiet(input int len, input string req);
        int highs = 0;
        for (int k = 0; k < len; k++) begin
            step();
            if (irq) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    initial begin
        int got;
        longint n;
        logic [15:0] incs [6] = '{16'h8000, 16'h4000, 16'hFFFF, 16'h5555, 16'h2000, 16'h7FFF};

        repeat (4) step();
        check(irq == 1'b0, "R1 in reset", irq, 0);
        rst_n = 1'b1;
        step();
        check(irq == 1'b0, "R1 after reset", irq, 0);

        // R2 / R6 sweep
        en = 1'b1;
        ne = 1'b1;
        foreach (incs[i]) begin
            for (int t = 1; t <= 3; t++) begin
                inc = incs[i];
                val = 24'(t);
                n = expect_n(longint'(incs[i]), t);
                strobe_push();
                measure(int'(n) + 20, got);
                check(got == n, $sformatf("R2 inc=%h T=%0d", incs[i], t), got, n);
                quiet(2 * int'(n) + 8, "R6 no refire");
            end
        end

        // R3 push mid-count
        inc = 16'h8000; val = 24'd2; n = expect_n(32768, 2);
        strobe_push();
        quiet(40, "R3 before second push");
        strobe_push();
        measure(int'(n) + 20, got);
        check(got == n, "R3 push restart", got, n);

        // R4 pop mid-count
        strobe_push();
        quiet(50, "R4 before pop");
        strobe_pop();
        measure(int'(n) + 20, got);
        check(got == n, "R4 pop restart", got, n);

        // R10 rearm after firing
        strobe_push();
        measure(int'(n) + 20, got);
        check(got == n, "R10 rearm", got, n);

        // R5 empty hold, then start on first high sample
        ne = 1'b0;
        strobe_push();
        quiet(3 * int'(n), "R5 empty");
        ne = 1'b1;
        measure(int'(n) + 20, got);
        check(got == n, "R5 start after nonempty", got, n);

        // R7 zero limit
        val = 24'd0;
        strobe_push();
        quiet(2000, "R7 zero limit");

        // R8 disable, then enable start
        val = 24'd2;
        en = 1'b0;
        strobe_push();
        quiet(3 * int'(n), "R8 disabled");
        en = 1'b1;
        measure(int'(n) + 20, got);
        check(got == n, "R8 start after enable", got, n);

        // R9 zero increment
        inc = 16'h0000;
        val = 24'd1;
        strobe_push();
        quiet(2000, "R9 zero increment");

        summary();
        $finish;
    end
endmodule